// File: doc/BRIEF.md
# Multicore Coherency Unit Register File

This block is the software-visible register bank of a multiprocessor coherency unit. It sits on a simple single-cycle bus that carries a byte address, a write flag, an access size in bytes, write data and registered read data. Only two pieces of state are kept: a one-bit enable flag and a 32-bit per-CPU power status word. The power status word can be written a byte, a halfword or a whole word at a time, starting at any of its four byte positions.

A read-only configuration word describes the processor cluster. It is built at elaboration from the CPU count parameter: a mask with one bit set for each present CPU, starting at bit 4, plus the CPU count minus one in the low bits. Every other offset in the 256-byte window reads as zero and ignores writes. This includes the invalidate-all offset, the two address filter offsets and the two access control offsets. Read data is registered and appears one cycle after the request.

Top module: `coh_unit_regs`

## Requirements
- R1: A valid write at offset 0x00 stores req_wdata bit 0 as the enable flag. A read at 0x00 returns that flag in bit 0, with bits 31:1 zero.
- R2: A read at offset 0x04 returns ((2^NCPU)-1) shifted left by 4, ORed with NCPU-1 (for NCPU=3 this is 0x72). Writes to 0x04 change no state. NCPU must lie between 1 and 4 and defaults to 1.
- R3: A read at offset 0x08+k, for k from 0 to 3, returns the power status word shifted right by 8*k bits, with zeros filling from the top.
- R4: A write at 0x08+k builds a lane mask from req_size: 0xFF for size 1, 0xFFFF for size 2, 0xFFFFFFFF for size 4. The mask is shifted left by 8*k and the status bits under it are cleared. The write data, ANDed with the unshifted mask and shifted by the same amount, is then merged in. Bits shifted past bit 31 are lost.
- R5: Offset 0x0C reads as zero, and writes to it change no state.
- R6: Every other offset reads as zero and ignores writes. This covers 0x01-0x03, 0x05-0x07, 0x40, 0x44, 0x50, 0x54 and the rest of the range up to 0xFF.
- R7: A write whose req_size is not 1, 2 or 4 changes neither the enable flag nor the status word, at any offset.
- R8: A synchronous reset clears the enable flag, the power status word and rsp_rdata to zero.
- R9: rsp_rdata is loaded on the clock edge that accepts a read (req_valid high, req_write low). It keeps its value through idle cycles and writes. Reads ignore req_size.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Bus request valid this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 8 | Byte offset inside the 256-byte window |
| req_size | input | 3 | Access size in bytes (1, 2 or 4 are valid) |
| req_wdata | input | 32 | Write data, right-aligned |
| rsp_rdata | output | 32 | Registered read data |

## Verification
The bench aims at the byte-lane merge at unaligned status offsets. A halfword or word write at 0x0B must drop the bits that move past bit 31. A design that wraps them, or that uses the wrong mask, leaves the lower bytes corrupted. Writes of size 0, 3 and 5 are sent to both stored registers; a design that does not reject them changes the flag or the status word. Writes to 0x01 and 0x0D sit next to real registers and must be ignored; an address decode that drops the low bits would let them through. The bench also checks that rsp_rdata holds across writes and idle cycles, and that the configuration word is correct for a CPU count other than the default.

// File: rtl/coh_regs_pkg.sv
package coh_regs_pkg;

    localparam int DATA_W  = 32;
    localparam int ADDR_W  = 8;
    localparam int SIZE_W  = 3;
    localparam int CPU_MAX = 4;

    localparam logic [SIZE_W-1:0] SZ_BYTE = 3'd1;
    localparam logic [SIZE_W-1:0] SZ_HALF = 3'd2;
    localparam logic [SIZE_W-1:0] SZ_WORD = 3'd4;

    localparam logic [ADDR_W-1:0] OFS_CTRL = 8'h00;
    localparam logic [ADDR_W-1:0] OFS_CFG  = 8'h04;
    localparam logic [ADDR_W-3:0] OFS_PWR_WORD = 6'h02;

    typedef struct packed {
        logic              valid;
        logic              write;
        logic [ADDR_W-1:0] addr;
        logic [SIZE_W-1:0] size;
        logic [DATA_W-1:0] wdata;
    } bus_req_t;

    function automatic logic size_ok(input logic [SIZE_W-1:0] sz);
        return (sz == SZ_BYTE) || (sz == SZ_HALF) || (sz == SZ_WORD);
    endfunction

    function automatic logic [DATA_W-1:0] lane_mask(input logic [SIZE_W-1:0] sz);
        logic [DATA_W-1:0] m;
        case (sz)
            SZ_BYTE: m = 32'h0000_00FF;
            SZ_HALF: m = 32'h0000_FFFF;
            SZ_WORD: m = 32'hFFFF_FFFF;
            default: m = '0;
        endcase
        return m;
    endfunction

    function automatic logic [4:0] lane_shift(input logic [1:0] lane);
        return {lane, 3'b000};
    endfunction

    function automatic logic in_pwr_range(input logic [ADDR_W-1:0] a);
        return a[ADDR_W-1:2] == OFS_PWR_WORD;
    endfunction

endpackage

// File: rtl/coh_cfg_word.sv
module coh_cfg_word
    import coh_regs_pkg::*;
#(
    parameter int NCPU = 1
) (
    output logic [DATA_W-1:0] cfg_word
);
    localparam int MASK_LSB = 4;
    localparam int CNT_W    = 2;

    logic [CPU_MAX-1:0] present;

    for (genvar c = 0; c < CPU_MAX; c++) begin : g_cpu
        if (c < NCPU) begin : g_on
            assign present[c] = 1'b1;
        end else begin : g_off
            assign present[c] = 1'b0;
        end
    end

    localparam logic [CNT_W-1:0] CNT_FIELD = CNT_W'(NCPU - 1);

    assign cfg_word = {{(DATA_W-MASK_LSB-CPU_MAX){1'b0}}, present,
                       {(MASK_LSB-CNT_W){1'b0}}, CNT_FIELD};
endmodule

// File: rtl/coh_pwr_status.sv
module coh_pwr_status
    import coh_regs_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [1:0]        lane,
    input  logic [SIZE_W-1:0] size,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] status
);
    logic [DATA_W-1:0] base_mask;
    logic [DATA_W-1:0] put_mask;
    logic [DATA_W-1:0] put_data;
    logic              accept;

    always_comb begin
        base_mask = lane_mask(size);
        put_mask  = base_mask << lane_shift(lane);
        put_data  = (wdata & base_mask) << lane_shift(lane);
        accept    = wr_en && size_ok(size);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            status <= '0;
        end else if (accept) begin
            status <= (status & ~put_mask) | put_data;
        end
    end

    AST_PWR_HOLD: assert property (@(posedge clk) disable iff (rst)
        !accept |=> $stable(status)); // R7

    AST_PWR_LANE_KEEP: assert property (@(posedge clk) disable iff (rst)
        accept |=> (((status ^ $past(status)) & ~$past(put_mask)) == '0)); // R4
endmodule

// File: rtl/coh_read_port.sv
module coh_read_port
    import coh_regs_pkg::*;
#(
    parameter int NCPU = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic              ctrl_bit,
    input  logic [DATA_W-1:0] cfg_word,
    input  logic [DATA_W-1:0] status,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] sel;

    always_comb begin
        if (addr == OFS_CTRL) begin
            sel = {{(DATA_W-1){1'b0}}, ctrl_bit};
        end else if (addr == OFS_CFG) begin
            sel = cfg_word;
        end else if (in_pwr_range(addr)) begin
            sel = status >> lane_shift(addr[1:0]);
        end else begin
            sel = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata <= '0;
        end else if (rd_en) begin
            rdata <= sel;
        end
    end

    AST_RD_HOLD: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> $stable(rdata)); // R9

    AST_RD_RAZ: assert property (@(posedge clk) disable iff (rst)
        (rd_en && addr != OFS_CTRL && addr != OFS_CFG && !in_pwr_range(addr))
        |=> (rdata == '0)); // R6

    AST_RD_CTRL_ZEXT: assert property (@(posedge clk) disable iff (rst)
        (rd_en && addr == OFS_CTRL) |=> (rdata[DATA_W-1:1] == '0)); // R1

    AST_RD_CFG_SHAPE: assert property (@(posedge clk) disable iff (rst)
        (rd_en && addr == OFS_CFG) |=> (rdata[DATA_W-1:8] == '0
            && $countones(rdata[7:4]) == NCPU && rdata[3:2] == 2'b00)); // R2
endmodule

// File: rtl/coh_unit_regs.sv
module coh_unit_regs
    import coh_regs_pkg::*;
#(
    parameter int NCPU = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [SIZE_W-1:0] req_size,
    input  logic [DATA_W-1:0] req_wdata,
    output logic [DATA_W-1:0] rsp_rdata
);
    bus_req_t          req;
    logic              ctrl_q;
    logic              ctrl_we;
    logic              pwr_we;
    logic              rd_en;
    logic [DATA_W-1:0] cfg_word;
    logic [DATA_W-1:0] pwr_status;

    always_comb begin
        req.valid = req_valid;
        req.write = req_write;
        req.addr  = req_addr;
        req.size  = req_size;
        req.wdata = req_wdata;
        ctrl_we   = req.valid && req.write && (req.addr == OFS_CTRL) && size_ok(req.size);
        pwr_we    = req.valid && req.write && in_pwr_range(req.addr);
        rd_en     = req.valid && !req.write;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= 1'b0;
        end else if (ctrl_we) begin
            ctrl_q <= req.wdata[0];
        end
    end

    AST_CTRL_HOLD: assert property (@(posedge clk) disable iff (rst)
        !ctrl_we |=> $stable(ctrl_q)); // R1

    coh_cfg_word #(.NCPU(NCPU)) i_cfg (
        .cfg_word (cfg_word)
    );

    coh_pwr_status i_pwr (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (pwr_we),
        .lane   (req.addr[1:0]),
        .size   (req.size),
        .wdata  (req.wdata),
        .status (pwr_status)
    );

    coh_read_port #(.NCPU(NCPU)) i_rd (
        .clk      (clk),
        .rst      (rst),
        .rd_en    (rd_en),
        .addr     (req.addr),
        .ctrl_bit (ctrl_q),
        .cfg_word (cfg_word),
        .status   (pwr_status),
        .rdata    (rsp_rdata)
    );

    initial begin
        AST_NCPU_RANGE: assert (NCPU >= 1 && NCPU <= CPU_MAX); // R2
    end
endmodule

// File: tb/test_coh_unit_regs.sv
`timescale 1ns/1ps
module test_coh_unit_regs;

    localparam int NCPU = 3;
    localparam int NV   = 19;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [7:0]  req_addr  = '0;
    logic [2:0]  req_size  = '0;
    logic [31:0] req_wdata = '0;
    logic [31:0] rsp_rdata;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    coh_unit_regs #(.NCPU(NCPU)) i_coh_unit_regs (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata),
        .rsp_rdata(rsp_rdata)
    );

    // {write addr, write size, write data, read addr, expected read}
    localparam logic [82:0] VEC [NV] = '{
        {8'h08, 3'd4, 32'h1234_5678, 8'h08, 32'h1234_5678},
        {8'h09, 3'd1, 32'hFFFF_FFAB, 8'h08, 32'h1234_AB78},
        {8'h0A, 3'd2, 32'h9999_CDEF, 8'h08, 32'hCDEF_AB78},
        {8'h0B, 3'd4, 32'h1122_3344, 8'h09, 32'h0044_EFAB},
        {8'h08, 3'd3, 32'hFFFF_FFFF, 8'h08, 32'h44EF_AB78},
        {8'h0B, 3'd2, 32'h0000_AA55, 8'h0B, 32'h0000_0055},
        {8'h00, 3'd4, 32'hFFFF_FFFE, 8'h00, 32'h0000_0000},
        {8'h00, 3'd1, 32'h0000_0003, 8'h00, 32'h0000_0001},
        {8'h00, 3'd0, 32'h0000_0000, 8'h00, 32'h0000_0001},
        {8'h04, 3'd4, 32'h0000_0000, 8'h04, 32'h0000_0072},
        {8'h0C, 3'd4, 32'hFFFF_FFFF, 8'h0C, 32'h0000_0000},
        {8'h40, 3'd4, 32'hFFFF_FFFF, 8'h08, 32'h55EF_AB78},
        {8'h50, 3'd4, 32'hFFFF_FFFF, 8'h40, 32'h0000_0000},
        {8'h54, 3'd4, 32'hFFFF_FFFF, 8'h54, 32'h0000_0000},
        {8'h0A, 3'd1, 32'h0000_0077, 8'h0A, 32'h0000_5577},
        {8'h01, 3'd1, 32'h0000_0000, 8'h00, 32'h0000_0001},
        {8'h0D, 3'd1, 32'h0000_00FF, 8'h08, 32'h5577_AB78},
        {8'h08, 3'd5, 32'h0000_0000, 8'h08, 32'h5577_AB78},
        {8'h44, 3'd2, 32'h0000_FFFF, 8'h01, 32'h0000_0000}
    };

    function automatic string vec_tag(input int i);
        case (i)
            0, 1, 2, 5: return "R4";
            3, 14:      return "R3";
            4, 8, 17:   return "R7";
            6, 7:       return "R1";
            9:          return "R2";
            10:         return "R5";
            default:    return "R6";
        endcase
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
        end
    endtask

    task automatic do_write(input logic [7:0] a, input logic [2:0] s, input logic [31:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_size = s; req_wdata = d;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
    endtask

    task automatic do_read(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_addr = a; req_size = 3'd4;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        d = rsp_rdata;
    endtask

    initial begin
        logic [31:0] rd;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R8: reset state
        check("R8", rsp_rdata, 32'h0);
        do_read(8'h08, rd); check("R8", rd, 32'h0);
        do_read(8'h00, rd); check("R8", rd, 32'h0);

        for (int i = 0; i < NV; i++) begin
            do_write(VEC[i][82:75], VEC[i][74:72], VEC[i][71:40]);
            do_read(VEC[i][39:32], rd);
            check(vec_tag(i), rd, VEC[i][31:0]);
        end

        // R9: read data holds across a write and idle cycles
        do_read(8'h04, rd); check("R2", rd, 32'h0000_0072);
        do_write(8'h00, 3'd4, 32'h0);
        repeat (2) @(negedge clk);
        check("R9", rsp_rdata, 32'h0000_0072);
        do_read(8'h00, rd); check("R1", rd, 32'h0);

        // R4: halfword at top lane drops the overflow byte
        do_write(8'h0B, 3'd2, 32'h0000_3C00);
        do_read(8'h08, rd); check("R4", rd, 32'h0077_AB78);

        // R8: mid-run reset
        do_write(8'h00, 3'd4, 32'h1);
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        check("R8", rsp_rdata, 32'h0);
        do_read(8'h00, rd); check("R8", rd, 32'h0);
        do_read(8'h08, rd); check("R8", rd, 32'h0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule